// File: doc/BRIEF.md
# Translation Fault Control Registers

This block holds the two control registers that software and the translation fault logic share when a virtual address cannot be translated. The first is a 64-bit faulting-address register. The second is an insertion-parameter register that packs a 6-bit page size and a 24-bit protection key, surrounded by reserved fields. The page size and key are always presented on dedicated outputs to a TLB-insert consumer.

Software writes either register through a simple write port and reads either one through a combinational read port. Every software write is checked at write time. A write with a nonzero reserved field, an unsupported page size, key bits set above the implemented width, or an address whose unimplemented upper bits are not a sign extension is refused. The register then keeps its old value, and a one-cycle fault pulse carries a cause code. A hardware translation-fault event loads the faulting address and reloads the insertion register from the accessed region's page size and identifier. When both arrive in the same cycle, the event takes priority over the software write.

Top module: `xlate_fault_regs`

## Requirements
- R1: After reset both registers read as zero, `ins_ps` and `ins_key` are zero, and `wr_fault` is low.
- R2: A software write to the address register (`sw_wr_sel`=0) whose bits 63 down to VA_BITS-1 are all equal stores all 64 bits, and `sw_rd_data` returns them when `sw_rd_sel`=0.
- R3: A software address write whose bits 63 down to VA_BITS-1 are not all equal leaves the register unchanged and raises a fault with cause 3.
- R4: A legal software write to the insertion register (`sw_wr_sel`=1) stores bits 7:2 as the page size and bits 31:8 as the key. Both appear on `ins_ps` and `ins_key` on the next cycle.
- R5: An insertion write with any nonzero bit in 63:32 or 1:0 leaves the register unchanged and raises a fault with cause 0.
- R6: An insertion write whose page size p has PS_MASK[p]=0 leaves the register unchanged and raises a fault with cause 1.
- R7: An insertion write with a nonzero key bit at or above position KEY_BITS of the key field leaves the register unchanged and raises a fault with cause 2.
- R8: When several insertion checks fail at once, the reported cause is chosen in the order reserved (0), then page size (1), then key (2).
- R9: A translation-fault event (`flt_valid`) loads the address register with `flt_vaddr`, the page size with `flt_ps` and the key with `flt_rid`. The reserved fields stay zero.
- R10: When an event and a software write occur in the same cycle, the event's values are stored, the write is discarded, and no write fault is raised.
- R11: A read of the insertion register (`sw_rd_sel`=1) returns {32'b0, key, page size, 2'b0}, with the reserved fields always zero.
- R12: A refused write produces `wr_fault` high for exactly the one cycle after the write's clock edge. A write that is accepted leaves `wr_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_sel | input | 1 | Write target: 0 address register, 1 insertion register |
| sw_wr_data | input | 64 | Software write value |
| sw_rd_sel | input | 1 | Read source: 0 address register, 1 insertion register |
| sw_rd_data | output | 64 | Selected register value |
| flt_valid | input | 1 | Translation-fault event |
| flt_vaddr | input | 64 | Faulting virtual address |
| flt_ps | input | 6 | Accessed region's page size |
| flt_rid | input | 24 | Accessed region's identifier |
| wr_fault | output | 1 | One-cycle pulse for a refused write |
| wr_fault_cause | output | 2 | 0 reserved field, 1 page size, 2 key, 3 address |
| ins_ps | output | 6 | Current page size for TLB insert |
| ins_key | output | 24 | Current protection key for TLB insert |

## Verification
The bench builds the block with VA_BITS=40, KEY_BITS=16 and a page-size mask that allows only sizes 12, 14, 16 and 22. With these values a random page size is usually illegal, a random key is often too wide, and a small disturbance of a sign-extended address lands outside the implemented range. The narrow 40-bit boundary and the 16-bit key edge can also be hit directly on both sides.

// File: rtl/xlate_fault_regs.sv
module xlate_fault_regs #(
  parameter int          VA_BITS  = 51,
  parameter int          KEY_BITS = 18,
  parameter logic [63:0] PS_MASK  = 64'h0000_0000_1555_5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic        sw_wr_sel,
  input  logic [63:0] sw_wr_data,
  input  logic        sw_rd_sel,
  output logic [63:0] sw_rd_data,
  input  logic        flt_valid,
  input  logic [63:0] flt_vaddr,
  input  logic [5:0]  flt_ps,
  input  logic [23:0] flt_rid,
  output logic        wr_fault,
  output logic [1:0]  wr_fault_cause,
  output logic [5:0]  ins_ps,
  output logic [23:0] ins_key
);
  localparam int          SH       = VA_BITS - 1;
  localparam logic [23:0] KEY_MASK = {24{1'b1}} >> (24 - KEY_BITS);

  logic [63:0] fa_q;
  logic [5:0]  ps_q;
  logic [23:0] key_q;

  logic        res_bad, ps_bad, key_bad, va_bad;
  logic        bad;
  logic [1:0]  cause;
  logic [63:0] va_hi;

  assign va_hi   = 64'($signed(sw_wr_data) >>> SH);
  assign va_bad  = (va_hi != '0) && (va_hi != '1);
  assign res_bad = (sw_wr_data[63:32] != '0) || (sw_wr_data[1:0] != '0);
  assign ps_bad  = !PS_MASK[sw_wr_data[7:2]];
  assign key_bad = (sw_wr_data[31:8] & ~KEY_MASK) != '0;

  always_comb begin
    if (!sw_wr_sel) begin
      bad   = va_bad;
      cause = 2'd3;
    end else begin
      bad   = res_bad || ps_bad || key_bad;
      cause = res_bad ? 2'd0 : ps_bad ? 2'd1 : 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa_q           <= '0;
      ps_q           <= '0;
      key_q          <= '0;
      wr_fault       <= 1'b0;
      wr_fault_cause <= 2'd0;
    end else begin
      wr_fault <= 1'b0;
      if (flt_valid) begin
        fa_q  <= flt_vaddr;
        ps_q  <= flt_ps;
        key_q <= flt_rid;
      end else if (sw_wr_en) begin
        if (bad) begin
          wr_fault       <= 1'b1;
          wr_fault_cause <= cause;
        end else if (!sw_wr_sel) begin
          fa_q <= sw_wr_data;
        end else begin
          ps_q  <= sw_wr_data[7:2];
          key_q <= sw_wr_data[31:8];
        end
      end
    end
  end

  assign sw_rd_data = sw_rd_sel ? {32'b0, key_q, ps_q, 2'b00} : fa_q;
  assign ins_ps     = ps_q;
  assign ins_key    = key_q;
endmodule

module xlate_fault_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic        sw_rd_sel,
  input logic [63:0] sw_rd_data,
  input logic        flt_valid,
  input logic [63:0] flt_vaddr,
  input logic [5:0]  flt_ps,
  input logic [23:0] flt_rid,
  input logic        wr_fault,
  input logic [5:0]  ins_ps,
  input logic [23:0] ins_key,
  input logic [63:0] fa_q
);
  AST_EVENT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> fa_q == $past(flt_vaddr) && ins_ps == $past(flt_ps) && ins_key == $past(flt_rid)); // R9
  AST_EVENT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> !wr_fault); // R10
  AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> $stable(fa_q) && $stable(ins_ps) && $stable(ins_key)); // R12
  AST_FAULT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> !wr_fault); // R12
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_sel |-> sw_rd_data[63:32] == '0 && sw_rd_data[1:0] == '0); // R11
endmodule

bind xlate_fault_regs xlate_fault_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_rd_sel(sw_rd_sel),
  .sw_rd_data(sw_rd_data), .flt_valid(flt_valid), .flt_vaddr(flt_vaddr),
  .flt_ps(flt_ps), .flt_rid(flt_rid), .wr_fault(wr_fault),
  .ins_ps(ins_ps), .ins_key(ins_key), .fa_q(fa_q)
);

// File: tb/sim_xlate_fault_regs.sv
module sim_xlate_fault_regs;
  localparam int          VA  = 40;
  localparam int          KB  = 16;
  localparam logic [63:0] PSM = 64'h0000_0000_0041_5000;

  logic        clk = 0, rst_n = 0;
  logic        sw_wr_en = 0, sw_wr_sel = 0, sw_rd_sel = 0, flt_valid = 0;
  logic [63:0] sw_wr_data = 0, flt_vaddr = 0, sw_rd_data;
  logic [5:0]  flt_ps = 0, ins_ps;
  logic [23:0] flt_rid = 0, ins_key;
  logic        wr_fault;
  logic [1:0]  wr_fault_cause;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_fa;
  logic [5:0]  m_ps;
  logic [23:0] m_key;

  always #10 clk = ~clk;

  xlate_fault_regs #(.VA_BITS(VA), .KEY_BITS(KB), .PS_MASK(PSM)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel),
    .sw_wr_data(sw_wr_data), .sw_rd_sel(sw_rd_sel), .sw_rd_data(sw_rd_data),
    .flt_valid(flt_valid), .flt_vaddr(flt_vaddr), .flt_ps(flt_ps), .flt_rid(flt_rid),
    .wr_fault(wr_fault), .wr_fault_cause(wr_fault_cause), .ins_ps(ins_ps), .ins_key(ins_key));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic addr_ok(logic [63:0] d);
    for (int i = VA; i < 64; i++) if (d[i] != d[VA-1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [2:0] ins_verdict(logic [63:0] d);
    if (d[63:32] != 0 || d[1:0] != 0) return 3'b100;
    if (!PSM[d[7:2]]) return 3'b101;
    if (d[31:8] >= (24'd1 << KB)) return 3'b110;
    return 3'b000;
  endfunction

  task automatic step(logic we, logic sel, logic [63:0] d, logic fv,
                      logic [63:0] va, logic [5:0] ps, logic [23:0] rid, string req);
    logic       e_flt;
    logic [1:0] e_cause;
    logic [2:0] v;
    sw_wr_en = we; sw_wr_sel = sel; sw_wr_data = d;
    flt_valid = fv; flt_vaddr = va; flt_ps = ps; flt_rid = rid;
    e_flt = 0; e_cause = 0;
    if (fv) begin
      m_fa = va; m_ps = ps; m_key = rid;
    end else if (we) begin
      if (!sel) begin
        if (addr_ok(d)) m_fa = d;
        else begin e_flt = 1; e_cause = 3; end
      end else begin
        v = ins_verdict(d);
        if (v[2]) begin e_flt = 1; e_cause = v[1:0]; end
        else begin m_ps = d[7:2]; m_key = d[31:8]; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    sw_wr_en = 0; flt_valid = 0;
    chk({req, " wr_fault"}, {63'b0, wr_fault}, {63'b0, e_flt});
    if (e_flt) chk({req, " cause"}, {62'b0, wr_fault_cause}, {62'b0, e_cause});
    sw_rd_sel = 0; #1;
    chk({req, " addr read"}, sw_rd_data, m_fa);
    sw_rd_sel = 1; #1;
    chk({req, " ins read R11"}, sw_rd_data, {32'b0, m_key, m_ps, 2'b00});
    chk({req, " ins outputs R4"}, {34'b0, ins_key, ins_ps}, {34'b0, m_key, m_ps});
  endtask

  function automatic logic [63:0] ins_word(logic [5:0] ps, logic [23:0] key);
    return {32'b0, key, ps, 2'b00};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [5:0]  pl [4];
    void'($urandom(32'd1234));
    pl[0] = 12; pl[1] = 14; pl[2] = 16; pl[3] = 22;
    m_fa = 0; m_ps = 0; m_key = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    sw_rd_sel = 0; #1; chk("R1 addr", sw_rd_data, 64'b0);
    sw_rd_sel = 1; #1; chk("R1 ins", sw_rd_data, 64'b0);
    chk("R1 wr_fault", {63'b0, wr_fault}, 64'b0);
    // R2 / R3 address boundary
    step(1, 0, 64'h0000_007F_FFFF_FFFF, 0, 0, 0, 0, "R2 top positive");
    step(1, 0, 64'hFFFF_FF80_0000_0000, 0, 0, 0, 0, "R2 bottom negative");
    step(1, 0, 64'h0000_0080_0000_0000, 0, 0, 0, 0, "R3 just out");
    step(1, 0, 64'h8000_0000_0000_0001, 0, 0, 0, 0, "R3 top bit");
    // R4 - R8 insertion checks
    step(1, 1, ins_word(14, 24'h00_ABCD), 0, 0, 0, 0, "R4 legal");
    step(1, 1, ins_word(14, 24'h00_1234) | 64'h1, 0, 0, 0, 0, "R5 low reserved");
    step(1, 1, ins_word(14, 24'h00_1234) | 64'h1_0000_0000, 0, 0, 0, 0, "R5 high reserved");
    step(1, 1, ins_word(13, 24'h00_1234), 0, 0, 0, 0, "R6 bad size");
    step(1, 1, ins_word(22, 24'h01_0000), 0, 0, 0, 0, "R7 key bit 16");
    step(1, 1, ins_word(22, 24'h00_FFFF), 0, 0, 0, 0, "R7 key max legal");
    step(1, 1, ins_word(13, 24'hFF_0000) | 64'h2, 0, 0, 0, 0, "R8 res over size");
    step(1, 1, ins_word(13, 24'hFF_0000), 0, 0, 0, 0, "R8 size over key");
    // R9 / R10 event and collision
    step(0, 0, 0, 1, 64'hDEAD_BEEF_0000_1234, 6'd28, 24'hFE_DCBA, "R9 event");
    step(1, 1, ins_word(12, 24'h1), 1, 64'h55, 6'd13, 24'h77_0000, "R10 collide ins");
    step(1, 0, 64'h1, 1, 64'hFFFF_0000_0000_0000, 6'd5, 24'h3, "R10 collide addr");
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'h9, 6'd12, 24'h4, "R10 collide bad write");
    // R12 pulse lasts one cycle
    step(1, 0, 64'h0100_0000_0000_0000, 0, 0, 0, 0, "R12 refused");
    step(0, 0, 0, 0, 0, 0, 0, "R12 idle after");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int          k;
      logic        sel, fv, we;
      logic [63:0] va;
      k   = int'($urandom_range(0, 9));
      sel = 1'($urandom);
      we  = k != 0;
      fv  = k == 9;
      if (!sel) begin
        d = {{24{1'b0}}, $urandom, 8'($urandom)};
        d = {{24{d[39]}}, d[39:0]};
        if ($urandom_range(0, 3) == 0) d[40 + $urandom_range(0, 23)] ^= 1'b1;
      end else begin
        d = ins_word(($urandom_range(0, 1) == 0) ? pl[$urandom_range(0, 3)] : 6'($urandom),
                     ($urandom_range(0, 3) == 0) ? 24'($urandom) : {8'b0, 16'($urandom)});
        if ($urandom_range(0, 5) == 0) d[$urandom_range(0, 1)] = 1'b1;
        if ($urandom_range(0, 5) == 0) d[32 + $urandom_range(0, 31)] = 1'b1;
      end
      va = {$urandom, $urandom};
      step(we, sel, d, fv, va, 6'($urandom), 24'($urandom), "R2-R12 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule